// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs the external memory cycles of an 8-bit processor core that shares one port between the low address byte and the data byte, and has a second port for the high address byte. The core asks for one of three cycles: a program fetch, a data read or a data write. Each request carries a 16-bit address and, for a write, a data byte. The sequencer then drives the ports and the active-low strobes in a fixed order of phases. It returns a one-cycle completion pulse and, for fetches and reads, the byte it captured from the shared port.

Every cycle follows the same four phases in order. In the address phase the low byte goes out on the shared port and the latch strobe is high, so an external latch can hold it. In the hold phase the address stays on the port with no strobe active. In the strobe phase the one strobe that matches the request goes low. In the release phase every strobe is inactive again. The length of each phase, in clocks, is a parameter.

A code fetch can also be served by on-chip code storage. When the local-code enable input is high, fetches below the local code size are not put on the bus. The block only returns a completion pulse flagged as local, and the core reads its own storage. When the enable is low, every fetch goes to the bus. Data reads and writes always go to the bus.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held, and after it, until a request is accepted: `addr_latch` and `mux_oe` are 0; `code_stb_n`, `rd_stb_n` and `wr_stb_n` are 1; `busy` and `done` are 0.
- R2: An accepted external request starts with `addr_latch` high for exactly T_ADDR clocks. During those clocks `mux_out` carries address bits 7..0, `mux_oe` is 1 and `high_addr` carries address bits 15..8.
- R3: A fetch (`req_kind` = 2'b00) sent to the bus holds `code_stb_n` low for exactly T_STRB clocks. `rdata` then equals the byte that was on `mux_in` in the last of those clocks.
- R4: A data read (`req_kind` = 2'b01; 2'b11 behaves the same) holds `rd_stb_n` low for exactly T_STRB clocks. `rdata` then equals the byte that was on `mux_in` in the last of those clocks.
- R5: A data write (`req_kind` = 2'b10) holds `wr_stb_n` low for exactly T_STRB clocks. Throughout those clocks `mux_oe` is 1 and `mux_out` equals the write byte.
- R6: While `code_stb_n` or `rd_stb_n` is low, `mux_oe` is 0.
- R7: At most one of `addr_latch`, the inverted `code_stb_n`, the inverted `rd_stb_n` and the inverted `wr_stb_n` is active in any clock.
- R8: A fetch is served locally when `code_local_en` is 1 and the address is below LOCAL_CODE_BYTES (0x1000). In that case no strobe moves, `busy` stays 0, and `done` and `done_local` pulse together in the clock after acceptance. Every other request uses the bus, and its `done` has `done_local` = 0.
- R9: `high_addr` does not change while `busy` is 1.
- R10: A request is accepted only on a clock edge where `req_valid` is 1 and `busy` is 0. A request held while `busy` is 1 is not started until the current cycle's `done`. Each accepted request yields exactly one `done`, in request order.
- R11: A bus cycle keeps `busy` high for exactly T_ADDR+T_HOLD+T_STRB+T_REL clocks. `done` is high in the first clock after that.
- R12: Between the latch pulse and the strobe there are exactly T_HOLD clocks with no strobe and no latch. After the strobe there are T_REL such clocks before `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| code_local_en | input | 1 | 1: low code addresses are served on chip |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| done_local | output | 1 | Completion was a local fetch |
| rdata | output | 8 | Byte captured by the last fetch or read |
| mux_out | output | 8 | Shared port output: low address, then write data |
| mux_oe | output | 1 | Output enable of the shared port |
| mux_in | input | 8 | Shared port input |
| high_addr | output | 8 | High address byte port |
| addr_latch | output | 1 | Active-high latch strobe for the low address |
| code_stb_n | output | 1 | Active-low program-store strobe |
| rd_stb_n | output | 1 | Active-low data read strobe |
| wr_stb_n | output | 1 | Active-low data write strobe |

## Verification
The assertions assume that the core never changes `req_kind`, `req_addr` or `req_wdata` in a way that matters outside an accepting edge. They also assume that `code_local_en` only changes while no request is pending. The bench follows both rules: it drives inputs only on falling edges, drops `req_valid` one clock after acceptance, and toggles the enable only between requests. The external memory model answers on `mux_in` only while a read-type strobe is low, using the address it latched during the latch pulse. A design that starts a held-off request early, or drives the wrong address, therefore shows up as a wrong returned byte.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the external bus sequencer.
// Assumes: request kind 2'b11 is treated as a data read by all users.
package xbus_pkg;

    // Request kind as presented by the core.
    typedef enum logic [1:0] {
        XK_FETCH = 2'b00,
        XK_READ  = 2'b01,
        XK_WRITE = 2'b10,
        XK_RDALT = 2'b11
    } xkind_t;

    // Phase of an external bus cycle.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_HOLD = 3'd2,
        PH_STRB = 3'd3,
        PH_REL  = 3'd4
    } xphase_t;

endpackage

// File: rtl/xbus_route.sv
`timescale 1ns/1ps
// Module: xbus_route
// Decides whether an incoming request is a fetch served by on-chip code
// storage (no bus cycle) or must go to the external bus.
// Assumes: only fetches can be local; data accesses always use the bus.
module xbus_route
    import xbus_pkg::*;
#(
    parameter int AW               = 16,
    parameter int LOCAL_CODE_BYTES = 4096
) (
    input  xkind_t          kind,
    input  logic [AW-1:0]   addr,
    input  logic            local_en,
    output logic            go_local
);

    localparam logic [AW:0] LIMIT = (AW+1)'(LOCAL_CODE_BYTES);

    // Local only for fetches below the on-chip code size when enabled.
    always_comb begin
        go_local = local_en && (kind == XK_FETCH) && ({1'b0, addr} < LIMIT);
    end

endmodule

// File: rtl/xbus_timer.sv
`timescale 1ns/1ps
// Module: xbus_timer
// Steps a bus cycle through address, hold, strobe and release phases,
// each lasting a parameterised number of clocks, and pulses done at the end.
// Assumes: every phase length is at least one clock; start is only honoured
// while idle.
module xbus_timer
    import xbus_pkg::*;
#(
    parameter int T_ADDR = 2,
    parameter int T_HOLD = 1,
    parameter int T_STRB = 3,
    parameter int T_REL  = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    start_local,
    output xphase_t phase,
    output logic    last_strb,
    output logic    busy,
    output logic    done,
    output logic    done_local
);

    localparam int TM1  = (T_ADDR > T_HOLD) ? T_ADDR : T_HOLD;
    localparam int TM2  = (T_STRB > T_REL)  ? T_STRB : T_REL;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          phase_end;
    xphase_t       phase_nx;

    // Last count value of the current phase.
    always_comb begin
        case (phase)
            PH_ADDR: lim = CW'(T_ADDR - 1);
            PH_HOLD: lim = CW'(T_HOLD - 1);
            PH_STRB: lim = CW'(T_STRB - 1);
            PH_REL:  lim = CW'(T_REL - 1);
            default: lim = '0;
        endcase
    end

    // Phase that follows the current one.
    always_comb begin
        case (phase)
            PH_ADDR: phase_nx = PH_HOLD;
            PH_HOLD: phase_nx = PH_STRB;
            PH_STRB: phase_nx = PH_REL;
            default: phase_nx = PH_IDLE;
        endcase
    end

    assign phase_end = (cnt == lim);
    assign last_strb = (phase == PH_STRB) && phase_end;
    assign busy      = (phase != PH_IDLE);

    // Phase register, in-phase counter and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            done       <= 1'b0;
            done_local <= 1'b0;
        end else begin
            done       <= 1'b0;
            done_local <= 1'b0;
            if (phase == PH_IDLE) begin
                cnt <= '0;
                if (start) begin
                    if (start_local) begin
                        done       <= 1'b1;
                        done_local <= 1'b1;
                    end else begin
                        phase <= PH_ADDR;
                    end
                end
            end else if (phase_end) begin
                cnt   <= '0;
                phase <= phase_nx;
                if (phase == PH_REL) begin
                    done <= 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10
    // busy only ever drops together with the completion pulse
    fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11
    // a cycle never ends before the release phase has finished
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(phase == PH_REL && phase_end)) |=> busy);

    // R2
    // every bus cycle enters at the first clock of the address phase
    entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (phase == PH_ADDR && cnt == '0));

endmodule

// File: rtl/xbus_pins.sv
`timescale 1ns/1ps
// Module: xbus_pins
// Decodes the current phase and the captured request into the shared port,
// high address port, latch strobe and the three active-low strobes.
// Assumes: phase and request fields come from registers, so outputs are
// settled well before the next edge.
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  xphase_t          phase,
    input  xkind_t           kind_q,
    input  logic [AW-1:0]    addr_q,
    input  logic [DW-1:0]    wdata_q,
    output logic [DW-1:0]    mux_out,
    output logic             mux_oe,
    output logic [AW-DW-1:0] high_addr,
    output logic             addr_latch,
    output logic             code_stb_n,
    output logic             rd_stb_n,
    output logic             wr_stb_n
);

    logic is_write;
    logic is_fetch;

    assign is_write  = (kind_q == XK_WRITE);
    assign is_fetch  = (kind_q == XK_FETCH);
    assign high_addr = addr_q[AW-1:DW];

    // Per-phase drive of the shared port and strobes.
    always_comb begin
        mux_out    = '0;
        mux_oe     = 1'b0;
        addr_latch = 1'b0;
        code_stb_n = 1'b1;
        rd_stb_n   = 1'b1;
        wr_stb_n   = 1'b1;
        case (phase)
            PH_ADDR: begin
                addr_latch = 1'b1;
                mux_out    = addr_q[DW-1:0];
                mux_oe     = 1'b1;
            end
            PH_HOLD: begin
                mux_out = addr_q[DW-1:0];
                mux_oe  = 1'b1;
            end
            PH_STRB: begin
                if (is_write) begin
                    mux_out  = wdata_q;
                    mux_oe   = 1'b1;
                    wr_stb_n = 1'b0;
                end else if (is_fetch) begin
                    code_stb_n = 1'b0;
                end else begin
                    rd_stb_n = 1'b0;
                end
            end
            PH_REL: begin
                if (is_write) begin
                    mux_out = wdata_q;
                    mux_oe  = 1'b1;
                end
            end
            default: begin
                mux_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
// Module: xbus_seq (top)
// Accepts fetch/read/write requests from the core, routes low code fetches
// on chip, and sequences external cycles on a shared low-address/data port.
// Assumes: the core holds a request until it sees busy low at an edge, and
// code_local_en only changes while no request is pending.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW               = 16,
    parameter int DW               = 8,
    parameter int LOCAL_CODE_BYTES = 4096,
    parameter int T_ADDR           = 2,
    parameter int T_HOLD           = 1,
    parameter int T_STRB           = 3,
    parameter int T_REL            = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             code_local_en,
    output logic             busy,
    output logic             done,
    output logic             done_local,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    mux_out,
    output logic             mux_oe,
    input  logic [DW-1:0]    mux_in,
    output logic [AW-DW-1:0] high_addr,
    output logic             addr_latch,
    output logic             code_stb_n,
    output logic             rd_stb_n,
    output logic             wr_stb_n
);

    xkind_t        kind_in;
    xkind_t        kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          accept;
    logic          go_local;
    logic          last_strb;
    xphase_t       phase;

    assign kind_in = xkind_t'(req_kind);
    assign accept  = req_valid && !busy;

    xbus_route #(
        .AW               (AW),
        .LOCAL_CODE_BYTES (LOCAL_CODE_BYTES)
    ) u_route (
        .kind     (kind_in),
        .addr     (req_addr),
        .local_en (code_local_en),
        .go_local (go_local)
    );

    xbus_timer #(
        .T_ADDR (T_ADDR),
        .T_HOLD (T_HOLD),
        .T_STRB (T_STRB),
        .T_REL  (T_REL)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_local (go_local),
        .phase       (phase),
        .last_strb   (last_strb),
        .busy        (busy),
        .done        (done),
        .done_local  (done_local)
    );

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= XK_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= kind_in;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the shared port at the last clock of a read-type strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (last_strb && (kind_q != XK_WRITE)) begin
            rdata <= mux_in;
        end
    end

    xbus_pins #(
        .AW (AW),
        .DW (DW)
    ) u_pins (
        .phase      (phase),
        .kind_q     (kind_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .mux_out    (mux_out),
        .mux_oe     (mux_oe),
        .high_addr  (high_addr),
        .addr_latch (addr_latch),
        .code_stb_n (code_stb_n),
        .rd_stb_n   (rd_stb_n),
        .wr_stb_n   (wr_stb_n)
    );

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({addr_latch, ~code_stb_n, ~rd_stb_n, ~wr_stb_n}) <= 1);

    // R5
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_n |-> (mux_oe && mux_out == wdata_q));

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_stb_n || !rd_stb_n) |-> !mux_oe);

    // R9
    high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(high_addr));

    // R2
    latch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (addr_latch && mux_oe));

    // R8
    local_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_local |-> (done && !busy && code_stb_n));

endmodule

// File: tb/xbus_seq_bench.sv
`timescale 1ns/1ps
module xbus_seq_bench;

    localparam int TA  = 2;
    localparam int TH  = 1;
    localparam int TS  = 3;
    localparam int TR  = 1;
    localparam int LIM = 4096;
    localparam int SUM = TA + TH + TS + TR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        code_local_en = 1'b1;
    logic        busy, done, done_local;
    logic [7:0]  rdata, mux_out, mux_in, high_addr;
    logic        mux_oe, addr_latch, code_stb_n, rd_stb_n, wr_stb_n;

    always #2.5 clk = ~clk;

    xbus_seq #(
        .LOCAL_CODE_BYTES (LIM),
        .T_ADDR (TA), .T_HOLD (TH), .T_STRB (TS), .T_REL (TR)
    ) u_xbus_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_kind (req_kind), .req_addr (req_addr), .req_wdata (req_wdata),
        .code_local_en (code_local_en), .busy (busy), .done (done),
        .done_local (done_local), .rdata (rdata), .mux_out (mux_out),
        .mux_oe (mux_oe), .mux_in (mux_in), .high_addr (high_addr),
        .addr_latch (addr_latch), .code_stb_n (code_stb_n),
        .rd_stb_n (rd_stb_n), .wr_stb_n (wr_stb_n)
    );

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wdata;
        bit          loc;
    } exp_t;

    exp_t q[$];
    int nchecks = 0;
    int nerr = 0;
    bit finished = 0;

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] data_byte(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h33;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // External memory model: latches the address during the latch pulse.
    logic [15:0] lat_addr = '0;
    assign mux_in = !code_stb_n ? code_byte(lat_addr) :
                    (!rd_stb_n ? data_byte(lat_addr) : 8'hFF);

    int n_lat = 0, n_cs = 0, n_rd = 0, n_wr = 0, n_busy = 0, n_gap = 0;
    int hi_bad = 0, oe_bad = 0, wr_oe_bad = 0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  prev_hi = '0;

    // Monitor: counts pin activity and scores each completion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_latch) begin
                lat_addr = {high_addr, mux_out};
                n_lat++;
            end
            if (!code_stb_n) n_cs++;
            if (!rd_stb_n) n_rd++;
            if (!wr_stb_n) begin
                n_wr++;
                wr_addr = lat_addr;
                wr_data = mux_out;
                if (!mux_oe) wr_oe_bad++;
            end
            if ((!code_stb_n || !rd_stb_n) && mux_oe) oe_bad++;
            if (busy) begin
                if (n_busy > 0 && high_addr != prev_hi) hi_bad++;
                n_busy++;
                if (!addr_latch && code_stb_n && rd_stb_n && wr_stb_n) n_gap++;
            end
            prev_hi = high_addr;
            if (done) begin
                if (q.size() == 0) begin
                    chk("R10 done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.loc) begin
                        chk("R8 local flag", int'(done_local), 1);
                        chk("R8 no latch on local fetch", n_lat, 0);
                        chk("R8 no busy on local fetch", n_busy, 0);
                    end else begin
                        chk("R8 bus completion flag", int'(done_local), 0);
                        chk("R2 latch length", n_lat, TA);
                        chk("R11 busy length", n_busy, SUM);
                        chk("R12 quiet clocks", n_gap, TH + TR);
                        chk("R9 high address stable", hi_bad, 0);
                        if (e.kind == 2'b00) begin
                            chk("R3 code strobe length", n_cs, TS);
                            chk("R3 other strobes", n_rd + n_wr, 0);
                            chk("R3 fetched byte", int'(rdata), int'(code_byte(e.addr)));
                        end else if (e.kind == 2'b10) begin
                            chk("R5 write strobe length", n_wr, TS);
                            chk("R2 write latched address", int'(wr_addr), int'(e.addr));
                            chk("R5 write data", int'(wr_data), int'(e.wdata));
                            chk("R5 write drive", wr_oe_bad, 0);
                        end else begin
                            chk("R4 read strobe length", n_rd, TS);
                            chk("R4 other strobes", n_cs + n_wr, 0);
                            chk("R4 read byte", int'(rdata), int'(data_byte(e.addr)));
                            chk("R6 port released", oe_bad, 0);
                        end
                    end
                end
                n_lat = 0; n_cs = 0; n_rd = 0; n_wr = 0; n_busy = 0; n_gap = 0;
                hi_bad = 0; oe_bad = 0; wr_oe_bad = 0;
            end
        end
    end

    // Driver: presents one request, pushes its expectation, drops valid.
    task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
        exp_t e;
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        req_wdata = d;
        e.kind = k; e.addr = a; e.wdata = d;
        e.loc  = (k == 2'b00) && code_local_en && (a < 16'(LIM));
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 latch idle", int'(addr_latch), 0);
        chk("R1 strobes idle", int'({code_stb_n, rd_stb_n, wr_stb_n}), 7);
        chk("R1 port released", int'(mux_oe), 0);
        chk("R1 busy/done idle", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'({busy, done, addr_latch}), 0);

        code_local_en = 1'b1;
        issue(2'b00, 16'h0123, 8'h00);   // R8 local
        issue(2'b00, 16'h0FFF, 8'h00);   // R8 boundary, local
        issue(2'b00, 16'h1000, 8'h00);   // R8 boundary, bus
        issue(2'b01, 16'h0010, 8'h00);   // R8 data never local
        issue(2'b10, 16'h0020, 8'hA5);   // R5
        issue(2'b10, 16'hBEEF, 8'h3C);   // R5
        while (busy) @(negedge clk);
        @(negedge clk);
        code_local_en = 1'b0;
        issue(2'b00, 16'h0123, 8'h00);   // R8 all fetches external
        issue(2'b00, 16'hFFFF, 8'h00);   // R3
        issue(2'b01, 16'h8001, 8'h00);   // R4

        // R10: second request held while the first is busy
        issue(2'b01, 16'h4455, 8'h00);
        begin
            exp_t e2;
            req_valid = 1'b1;
            req_kind  = 2'b00;
            req_addr  = 16'h7766;
            e2.kind = 2'b00; e2.addr = 16'h7766; e2.wdata = 8'h00; e2.loc = 1'b0;
            q.push_back(e2);
            chk("R10 held request sees busy", int'(busy), 1);
            while (busy) begin
                chk("R10 first cycle keeps its address", int'(high_addr), 16'h44);
                @(negedge clk);
            end
            @(negedge clk);
            req_valid = 1'b0;
        end

        while (busy) @(negedge clk);
        @(negedge clk);
        code_local_en = 1'b1;
        issue(2'b00, 16'h0200, 8'h00);   // R8 local, then bus back to back
        issue(2'b01, 16'h1234, 8'h00);
        issue(2'b11, 16'h2301, 8'h00);   // R4 alternate read code

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 no stray cycle", int'(busy), 0);
        chk("R1 strobes idle at end", int'({code_stb_n, rd_stb_n, wr_stb_n}), 7);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule